// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block turns a pointer access request into an effective memory address. A request names one of three 16-bit pointer pairs (X, Y or Z), gives that pair's low and high bytes, picks an addressing mode and may carry a 6-bit unsigned displacement. The block returns the address for the access. It also returns the updated pointer, split back into bytes, with a write-back enable that tells the register file whether to store it. For extended program-memory reads through Z, a page value is placed above the 16 pointer bits to form a 22-bit address. Post-increment then carries out of Z into the page, and pre-decrement borrows from it. The updated page comes back with its own write enable.

Requests enter on a valid/ready channel and results leave on another. There is one registered stage between them. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` after that edge. The result stays unchanged until an edge where `rsp_ready` is high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-to-back transfers run at full rate.

Top module: `ptr_agu`

## Requirements
- R1: The pointer is `{req_ptr_hi, req_ptr_lo}`. In plain mode (`req_mode` = 0) the address is that pointer, `rsp_wb_en` and `rsp_page_we` are low, and the returned bytes equal the original pointer.
- R2: In post-increment mode (`req_mode` = 1) the address is the original pointer, the returned bytes hold pointer + 1 (low byte bits 7:0, high byte bits 15:8), and `rsp_wb_en` is high.
- R3: In pre-decrement mode (`req_mode` = 2) the pointer is decremented first. Both the address and the returned bytes use the decremented value, and `rsp_wb_en` is high.
- R4: In displacement mode (`req_mode` = 3) with Y (`req_sel` = 1) or Z (`req_sel` = 2), the address is the pointer plus the zero-extended displacement, modulo 2^16. The returned bytes equal the original pointer and `rsp_wb_en` is low.
- R5: Displacement mode with X (`req_sel` = 0), or with the reserved select 3, ignores the displacement. The address is the plain pointer and there is no write-back.
- R6: Without the extended mode, pointer arithmetic wraps modulo 2^16: 0x0000 pre-decremented gives 0xFFFF, and 0xFFFF post-incremented gives 0x0000. Address bits 21:16 are zero.
- R7: When `req_ext` is high and `req_sel` selects Z, the address is `{req_page[5:0], Z}`. Page bits 7:6 are ignored, and `rsp_page` returns the page that goes with the updated pointer.
- R8: In extended mode, post-increment of Z = 0xFFFF carries into the page, so page 0x05 becomes 0x06. Page 0x3F wraps to 0x00. Pre-decrement of Z = 0x0000 borrows from the page. `rsp_page_we` is high for extended post-increment and pre-decrement.
- R9: `req_ext` has no effect unless Z is selected. Without the extended mode, `rsp_page` is zero and `rsp_page_we` is low. `rsp_page_we` is never high without `rsp_wb_en`.
- R10: After reset `rsp_valid` is low. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every result output holds its value. `rsp_wb_sel` echoes the request's pointer select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 reserved (acts as X) |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| req_ext | input | 1 | Extended program-memory access (Z only) |
| req_disp | input | 6 | Unsigned displacement |
| req_ptr_lo | input | 8 | Pointer low byte |
| req_ptr_hi | input | 8 | Pointer high byte |
| req_page | input | 8 | Extended page value; only bits 5:0 are used |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_addr | output | 22 | Effective address |
| rsp_wb_en | output | 1 | Pointer write-back enable |
| rsp_wb_sel | output | 2 | Pointer pair to write back |
| rsp_wb_lo | output | 8 | Updated pointer low byte |
| rsp_wb_hi | output | 8 | Updated pointer high byte |
| rsp_page_we | output | 1 | Page write-back enable |
| rsp_page | output | 6 | Updated page value |

## Verification
The hardest cases to reach are the ones where the 16-bit pointer arithmetic crosses its limit while the extended page is active. Z must sit at exactly 0xFFFF or 0x0000, with a page whose increment either moves into the next page or wraps at 0x3F. The stimulus table places those pointer and page values directly on the request bytes. The same wrap values are also sent without `req_ext`, and with a non-Z select, to show that the page is left alone. A separate directed sequence holds `rsp_ready` low while a second request waits. Its result must appear only after the first one drains.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  localparam int unsigned PTR_BYTE_W = 8;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned MODE_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_X   = 2'd0,
    SEL_Y   = 2'd1,
    SEL_Z   = 2'd2,
    SEL_RSV = 2'd3
  } ptr_sel_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_POSTINC = 2'd1,
    MODE_PREDEC  = 2'd2,
    MODE_DISP    = 2'd3
  } ptr_mode_e;
endpackage

// File: rtl/ptr_agu_form.sv
module ptr_agu_form
  import ptr_agu_pkg::*;
#(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned PAGE_IN_W = 8,
  localparam int unsigned FULL_W   = PTR_W + PAGE_W
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 ext,
  input  logic [PTR_W/2-1:0]   ptr_lo,
  input  logic [PTR_W/2-1:0]   ptr_hi,
  input  logic [PAGE_IN_W-1:0] page_in,
  output logic [PTR_W-1:0]     ptr,
  output logic                 ext_act,
  output logic [FULL_W-1:0]    full
);
  always_comb begin
    ptr     = {ptr_hi, ptr_lo};
    ext_act = ext && (sel == SEL_Z);
    if (ext_act) full = {page_in[PAGE_W-1:0], ptr};
    else         full = {{PAGE_W{1'b0}}, ptr};
  end
endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
  import ptr_agu_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned DISP_W = 6,
  localparam int unsigned FULL_W = PTR_W + PAGE_W
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [MODE_W-1:0] mode,
  input  logic              ext_act,
  input  logic [DISP_W-1:0] disp,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [FULL_W-1:0] full,
  output logic [FULL_W-1:0] addr,
  output logic [FULL_W-1:0] next_val,
  output logic              wb_en,
  output logic              page_we
);
  logic [PTR_W-1:0]  disp_ext;
  logic [PTR_W-1:0]  disp_sum;
  logic [FULL_W-1:0] inc_val;
  logic [FULL_W-1:0] dec_val;
  logic              disp_ok;

  generate
    if (DISP_W < PTR_W) begin : g_zext
      assign disp_ext = {{(PTR_W-DISP_W){1'b0}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PTR_W-1:0];
    end
  endgenerate

  always_comb begin
    disp_sum = ptr + disp_ext;
    disp_ok  = (sel == SEL_Y) || (sel == SEL_Z);
    if (ext_act) begin
      inc_val = full + {{(FULL_W-1){1'b0}}, 1'b1};
      dec_val = full - {{(FULL_W-1){1'b0}}, 1'b1};
    end else begin
      inc_val = {{PAGE_W{1'b0}}, ptr + {{(PTR_W-1){1'b0}}, 1'b1}};
      dec_val = {{PAGE_W{1'b0}}, ptr - {{(PTR_W-1){1'b0}}, 1'b1}};
    end
    addr     = full;
    next_val = full;
    wb_en    = 1'b0;
    unique case (mode)
      MODE_POSTINC: begin
        next_val = inc_val;
        wb_en    = 1'b1;
      end
      MODE_PREDEC: begin
        addr     = dec_val;
        next_val = dec_val;
        wb_en    = 1'b1;
      end
      MODE_DISP: begin
        if (disp_ok) addr = {full[FULL_W-1:PTR_W], disp_sum};
      end
      default: ;
    endcase
    page_we = wb_en && ext_act;
  end
endmodule

// File: rtl/ptr_agu_stage.sv
module ptr_agu_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned PAGE_IN_W = 8,
  parameter int unsigned DISP_W    = 6,
  localparam int unsigned FULL_W   = PTR_W + PAGE_W,
  localparam int unsigned BYTE_W   = PTR_W / 2,
  localparam int unsigned RES_W    = FULL_W + PTR_W + PAGE_W + SEL_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic                 req_ext,
  input  logic [DISP_W-1:0]    req_disp,
  input  logic [BYTE_W-1:0]    req_ptr_lo,
  input  logic [BYTE_W-1:0]    req_ptr_hi,
  input  logic [PAGE_IN_W-1:0] req_page,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [FULL_W-1:0]    rsp_addr,
  output logic                 rsp_wb_en,
  output logic [SEL_W-1:0]     rsp_wb_sel,
  output logic [BYTE_W-1:0]    rsp_wb_lo,
  output logic [BYTE_W-1:0]    rsp_wb_hi,
  output logic                 rsp_page_we,
  output logic [PAGE_W-1:0]    rsp_page
);
  logic [PTR_W-1:0]  ptr;
  logic              ext_act;
  logic [FULL_W-1:0] full;
  logic [FULL_W-1:0] addr;
  logic [FULL_W-1:0] next_val;
  logic              wb_en;
  logic              page_we;
  logic [RES_W-1:0]  res_in;
  logic [RES_W-1:0]  res_out;

  ptr_agu_form #(
    .PTR_W(PTR_W), .PAGE_W(PAGE_W), .PAGE_IN_W(PAGE_IN_W)
  ) u_form (
    .sel(req_sel), .ext(req_ext), .ptr_lo(req_ptr_lo), .ptr_hi(req_ptr_hi),
    .page_in(req_page), .ptr(ptr), .ext_act(ext_act), .full(full)
  );

  ptr_agu_calc #(
    .PTR_W(PTR_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W)
  ) u_calc (
    .sel(req_sel), .mode(req_mode), .ext_act(ext_act), .disp(req_disp),
    .ptr(ptr), .full(full), .addr(addr), .next_val(next_val),
    .wb_en(wb_en), .page_we(page_we)
  );

  assign res_in = {addr, next_val[PTR_W-1:0], next_val[FULL_W-1:PTR_W],
                   req_sel, wb_en, page_we};

  ptr_agu_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(res_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(res_out)
  );

  assign {rsp_addr, rsp_wb_hi, rsp_wb_lo, rsp_page, rsp_wb_sel,
          rsp_wb_en, rsp_page_we} = res_out;
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int unsigned FULL_W = 22,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_sel,
  input logic [1:0]        req_mode,
  input logic              req_ext,
  input logic [BYTE_W-1:0] req_ptr_lo,
  input logic [BYTE_W-1:0] req_ptr_hi,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [FULL_W-1:0] rsp_addr,
  input logic              rsp_wb_en,
  input logic [BYTE_W-1:0] rsp_wb_lo,
  input logic [BYTE_W-1:0] rsp_wb_hi,
  input logic              rsp_page_we
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_block_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_wb_lo) && $stable(rsp_wb_hi) && $stable(rsp_wb_en)));

  p_postinc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == 2'd1 && !(req_ext && req_sel == 2'd2)) |=>
      (rsp_valid && rsp_wb_en &&
       {rsp_wb_hi, rsp_wb_lo} == ($past({req_ptr_hi, req_ptr_lo}) + 16'd1) &&
       rsp_addr[15:0] == $past({req_ptr_hi, req_ptr_lo})));

  p_predec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_mode == 2'd2) |=>
      (rsp_wb_en && rsp_addr[15:0] == {rsp_wb_hi, rsp_wb_lo}));

  p_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_mode == 2'd0 || req_mode == 2'd3)) |=>
      (!rsp_wb_en && !rsp_page_we));

  p_page_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_page_we) |-> rsp_wb_en);
endmodule

bind ptr_agu ptr_agu_chk #(.FULL_W(FULL_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_sel(req_sel), .req_mode(req_mode), .req_ext(req_ext),
  .req_ptr_lo(req_ptr_lo), .req_ptr_hi(req_ptr_hi),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_wb_en(rsp_wb_en), .rsp_wb_lo(rsp_wb_lo), .rsp_wb_hi(rsp_wb_hi),
  .rsp_page_we(rsp_page_we)
);

// File: tb/tb_ptr_agu.sv
module tb_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [1:0]  req_mode = '0;
  logic        req_ext = 1'b0;
  logic [5:0]  req_disp = '0;
  logic [7:0]  req_ptr_lo = '0;
  logic [7:0]  req_ptr_hi = '0;
  logic [7:0]  req_page = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [21:0] rsp_addr;
  logic        rsp_wb_en;
  logic [1:0]  rsp_wb_sel;
  logic [7:0]  rsp_wb_lo;
  logic [7:0]  rsp_wb_hi;
  logic        rsp_page_we;
  logic [5:0]  rsp_page;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptr_agu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode), .req_ext(req_ext),
    .req_disp(req_disp), .req_ptr_lo(req_ptr_lo), .req_ptr_hi(req_ptr_hi),
    .req_page(req_page), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_wb_en(rsp_wb_en), .rsp_wb_sel(rsp_wb_sel),
    .rsp_wb_lo(rsp_wb_lo), .rsp_wb_hi(rsp_wb_hi),
    .rsp_page_we(rsp_page_we), .rsp_page(rsp_page)
  );

  // {sel, mode, ext, disp, ptr, page, exp_addr, exp_wb, exp_page, exp_en, exp_pwe}
  localparam int NV = 14;
  localparam logic [80:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 6'h00, 16'h1234, 8'h00, 22'h001234, 16'h1234, 6'h00, 1'b0, 1'b0},
    {2'd0, 2'd1, 1'b0, 6'h00, 16'h1234, 8'h00, 22'h001234, 16'h1235, 6'h00, 1'b1, 1'b0},
    {2'd1, 2'd2, 1'b0, 6'h00, 16'h0100, 8'h00, 22'h0000FF, 16'h00FF, 6'h00, 1'b1, 1'b0},
    {2'd1, 2'd3, 1'b0, 6'h3F, 16'h1000, 8'h00, 22'h00103F, 16'h1000, 6'h00, 1'b0, 1'b0},
    {2'd2, 2'd3, 1'b0, 6'h01, 16'hFFFF, 8'h00, 22'h000000, 16'hFFFF, 6'h00, 1'b0, 1'b0},
    {2'd0, 2'd3, 1'b0, 6'h3F, 16'h2000, 8'h00, 22'h002000, 16'h2000, 6'h00, 1'b0, 1'b0},
    {2'd2, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00, 22'h00FFFF, 16'hFFFF, 6'h00, 1'b1, 1'b0},
    {2'd0, 2'd1, 1'b0, 6'h00, 16'hFFFF, 8'h00, 22'h00FFFF, 16'h0000, 6'h00, 1'b1, 1'b0},
    {2'd2, 2'd0, 1'b1, 6'h00, 16'hABCD, 8'hC5, 22'h05ABCD, 16'hABCD, 6'h05, 1'b0, 1'b0},
    {2'd2, 2'd1, 1'b1, 6'h00, 16'hFFFF, 8'h05, 22'h05FFFF, 16'h0000, 6'h06, 1'b1, 1'b1},
    {2'd2, 2'd1, 1'b1, 6'h00, 16'hFFFF, 8'h3F, 22'h3FFFFF, 16'h0000, 6'h00, 1'b1, 1'b1},
    {2'd2, 2'd2, 1'b1, 6'h00, 16'h0000, 8'h06, 22'h05FFFF, 16'hFFFF, 6'h05, 1'b1, 1'b1},
    {2'd1, 2'd1, 1'b1, 6'h00, 16'h00FF, 8'h05, 22'h0000FF, 16'h0100, 6'h00, 1'b1, 1'b0},
    {2'd2, 2'd1, 1'b0, 6'h00, 16'hFFFF, 8'h05, 22'h00FFFF, 16'h0000, 6'h00, 1'b1, 1'b0}
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9, 10, 11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [34:0] stim);
    {req_sel, req_mode, req_ext, req_disp, req_ptr_hi, req_ptr_lo, req_page} = stim;
    req_valid = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "idle after reset",
          64'({rsp_valid, req_ready}), 64'b01);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] ea;
      logic [15:0] ew;
      logic [5:0]  ep;
      logic        een, epw;
      logic [1:0]  es;
      {ea, ew, ep, een, epw} = VEC[i][45:0];
      es = VEC[i][80:79];
      drive(VEC[i][80:46]);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_addr == ea && rsp_wb_sel == es, vec_req(i), "address",
            64'({rsp_valid, rsp_wb_sel, rsp_addr}), 64'({1'b1, es, ea}));
      check({rsp_wb_hi, rsp_wb_lo} == ew && rsp_page == ep && rsp_wb_en == een &&
            rsp_page_we == epw, vec_req(i), "writeback",
            64'({rsp_wb_hi, rsp_wb_lo, rsp_page, rsp_wb_en, rsp_page_we}),
            64'({ew, ep, een, epw}));
    end

    // R10 back-pressure: hold first result, second request must wait
    @(negedge clk);
    rsp_ready = 1'b0;
    drive({2'd0, 2'd1, 1'b0, 6'h00, 16'h0010, 8'h00});
    @(negedge clk);
    drive({2'd1, 2'd2, 1'b0, 6'h00, 16'h0200, 8'h00});
    check(req_ready == 1'b0, "R10", "ready low while stalled", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_addr == 22'h000010 && {rsp_wb_hi, rsp_wb_lo} == 16'h0011,
          "R10", "stalled result held",
          64'({rsp_valid, rsp_addr, rsp_wb_hi, rsp_wb_lo}), 64'({1'b1, 22'h000010, 16'h0011}));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_addr == 22'h0001FF && rsp_wb_sel == 2'd1, "R10",
          "queued request after drain", 64'({rsp_valid, rsp_wb_sel, rsp_addr}),
          64'({1'b1, 2'd1, 22'h0001FF}));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10", "drained", 64'(rsp_valid), 64'd0);

    // R9: reserved select with displacement and ext behaves as plain X
    drive({2'd3, 2'd3, 1'b1, 6'h20, 16'h4000, 8'h3F});
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_addr == 22'h004000 && !rsp_page_we && !rsp_wb_en && rsp_page == 6'h00,
          "R9", "reserved select ignores ext and disp",
          64'({rsp_addr, rsp_page_we, rsp_wb_en, rsp_page}), 64'({22'h004000, 8'h00}));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule